// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits on the internal bus between its masters (the processor path and a DMA engine) and a slow external memory cycle generator. It holds one external write. A master that has the bus gets its write acknowledged in the same cycle, and the external cycle then runs from the buffer while the internal bus carries other traffic. Accesses to the on-chip peripheral region pass straight through and can overtake a pending external write. External reads wait until the buffer has drained, so they never pass a write. A read that follows a write to the same address therefore shows software when that write has landed.

A master holds its request (valid, kind, region, address, data, byte enables, master identity) steady until it sees `req_ack`. The arbiter signals ownership through `bus_grant`. Peripheral accesses are single-cycle: they are strobed and completed in one clock. The external side is a level request. It is held until the external timing generator pulses `ext_done`.

Top module: `posted_wbuf`

## Requirements
- R1: After reset the buffer is empty: `ext_req` and `req_ack` are low while no request is presented.
- R2: An external write (`req_write`=1, `req_periph`=0) presented with `bus_grant` high and the buffer empty is acknowledged in that same cycle. From the next cycle, `ext_req` and `ext_write` are high and `ext_addr`, `ext_wdata` and `ext_be` carry the captured address, data and byte enables.
- R3: While `bus_grant` is low, no request of any kind is acknowledged and `per_req` stays low. The acknowledge arrives in the first cycle that `bus_grant` is high.
- R4: An external write presented while the buffer is full is not acknowledged, including in the cycle of `ext_done`. It is acknowledged in the cycle after `ext_done`.
- R5: A buffered write keeps `ext_req`, `ext_write` and its address, data and byte enables unchanged until `ext_done`. The cycle after `ext_done` it is gone, and `ext_req` is low if nothing else is pending.
- R6: A peripheral-region read or write (`req_periph`=1) with the bus granted raises `per_req` and `req_ack` in the same cycle, even while an external write is buffered. A peripheral read returns `per_rdata` on `req_rdata`, and the buffered external cycle is left unchanged.
- R7: An external read is not started while the buffer holds a write. Once the buffer is empty, `ext_req` is high with `ext_write` low and `ext_addr` equal to the read address. `req_ack` and `req_rdata`=`ext_rdata` come in the cycle `ext_done` is high.
- R8: A read of the address of a buffered write completes only after that write's `ext_done`, with at least one cycle between that pulse and the read acknowledge.
- R9: The master identity is stored with the entry: `ext_dma` follows the `req_dma` of the buffered write. A DMA peripheral read proceeds during a pending DMA write, but a DMA external read waits for the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_grant | input | 1 | Requesting master owns the internal bus |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_write | input | 1 | 1 write, 0 read |
| req_periph | input | 1 | 1 on-chip peripheral region, 0 external region |
| req_dma | input | 1 | 1 request from DMA engine, 0 from processor |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Write byte enables |
| req_ack | output | 1 | Request complete (one-cycle pulse per request) |
| req_rdata | output | DW | Read data, valid with `req_ack` on reads |
| per_req | output | 1 | Single-cycle peripheral access strobe |
| per_write | output | 1 | Peripheral access is a write |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_be | output | DW/8 | Peripheral byte enables |
| per_rdata | input | DW | Peripheral read data, same cycle |
| ext_req | output | 1 | External cycle requested, held until `ext_done` |
| ext_write | output | 1 | External cycle is the buffered write |
| ext_dma | output | 1 | Master that owns the external cycle is DMA |
| ext_addr | output | AW | External address |
| ext_wdata | output | DW | External write data |
| ext_be | output | DW/8 | External byte enables |
| ext_done | input | 1 | External cycle finished (one-cycle pulse) |
| ext_rdata | input | DW | External read data, valid with `ext_done` |

## Verification
The checks assume that each master holds its whole request unchanged from the cycle it is raised until the cycle it is acknowledged. They also assume that `ext_done` pulses for one cycle and only while `ext_req` is high. The bench changes its inputs only on falling edges. It drops or changes a request only after it has observed `req_ack`. It raises `ext_done` only while it can see an external cycle outstanding and releases it on the next falling edge, so every scenario stays within those rules.

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_grant,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_periph,
  input  logic            req_dma,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic            req_ack,
  output logic [DW-1:0]   req_rdata,
  output logic            per_req,
  output logic            per_write,
  output logic [AW-1:0]   per_addr,
  output logic [DW-1:0]   per_wdata,
  output logic [DW/8-1:0] per_be,
  input  logic [DW-1:0]   per_rdata,
  output logic            ext_req,
  output logic            ext_write,
  output logic            ext_dma,
  output logic [AW-1:0]   ext_addr,
  output logic [DW-1:0]   ext_wdata,
  output logic [DW/8-1:0] ext_be,
  input  logic            ext_done,
  input  logic [DW-1:0]   ext_rdata
);
  localparam int BW = DW / 8;

  logic          held;
  logic          held_dma;
  logic [AW-1:0] held_addr;
  logic [DW-1:0] held_data;
  logic [BW-1:0] held_be;

  logic owned, post_go, xrd_go;

  assign owned   = req_valid & bus_grant;
  assign post_go = owned & ~req_periph & req_write & ~held;
  assign xrd_go  = owned & ~req_periph & ~req_write & ~held;

  assign per_req   = owned & req_periph;
  assign per_write = req_write;
  assign per_addr  = req_addr;
  assign per_wdata = req_wdata;
  assign per_be    = req_be;

  assign ext_req   = held | xrd_go;
  assign ext_write = held;
  assign ext_dma   = held ? held_dma : req_dma;
  assign ext_addr  = held ? held_addr : req_addr;
  assign ext_wdata = held_data;
  assign ext_be    = held ? held_be : '0;

  assign req_ack   = per_req | post_go | (xrd_go & ext_done);
  assign req_rdata = req_periph ? per_rdata : ext_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_dma  <= 1'b0;
      held_addr <= '0;
      held_data <= '0;
      held_be   <= '0;
    end else if (post_go) begin
      held      <= 1'b1;
      held_dma  <= req_dma;
      held_addr <= req_addr;
      held_data <= req_wdata;
      held_be   <= req_be;
    end else if (held && ext_done) begin
      held      <= 1'b0;
    end
  end
endmodule

// File: rtl/posted_wbuf_chk.sv
module posted_wbuf_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_grant,
  input logic            req_valid,
  input logic            req_write,
  input logic            req_periph,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic            req_ack,
  input logic            per_req,
  input logic            ext_write,
  input logic [AW-1:0]   ext_addr,
  input logic [DW-1:0]   ext_wdata,
  input logic [DW/8-1:0] ext_be,
  input logic            ext_done
);
  a_r3_no_ack_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |-> !req_ack && !per_req);

  a_r4_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    ext_write && req_valid && req_write && !req_periph |-> !req_ack);

  a_r5_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ext_write && !ext_done |=> ext_write && $stable(ext_addr) && $stable(ext_wdata) && $stable(ext_be));

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ext_write && ext_done |=> !ext_write);

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack && req_write && !req_periph |=> ext_write && ext_addr == $past(req_addr) && ext_wdata == $past(req_wdata));

  a_r6_periph_free: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_periph && bus_grant |-> req_ack && per_req);

  a_r7_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack && !req_write && !req_periph |-> !ext_write && ext_done);
endmodule

bind posted_wbuf posted_wbuf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .req_valid(req_valid),
  .req_write(req_write), .req_periph(req_periph), .req_addr(req_addr),
  .req_wdata(req_wdata), .req_ack(req_ack), .per_req(per_req),
  .ext_write(ext_write), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
  .ext_be(ext_be), .ext_done(ext_done)
);

// File: tb/posted_wbuf_tb.sv
module posted_wbuf_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_grant = 0, req_valid = 0, req_write = 0, req_periph = 0, req_dma = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, per_rdata = 0, ext_rdata = 0;
  logic [3:0]  req_be = 0;
  logic        ext_done = 0;
  logic        req_ack, per_req, per_write, ext_req, ext_write, ext_dma;
  logic [31:0] req_rdata, per_addr, per_wdata, ext_addr, ext_wdata;
  logic [3:0]  per_be, ext_be;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  posted_wbuf u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #5; endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; bus_grant = 1; ext_done = 0;
    #5;
  endtask

  task automatic present(input bit wr, input bit pr, input bit dm, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_periph = pr; req_dma = dm;
    req_addr = a; req_wdata = d; req_be = be; bus_grant = 1;
    #5;
  endtask

  task automatic drain();
    @(negedge clk); ext_done = 1; #5;
    @(negedge clk); ext_done = 0; #5;
  endtask

  task automatic post(input logic [31:0] a, input logic [31:0] d, input bit dm);
    present(1, 0, dm, a, d, 4'hF);
    chk(req_ack === 1, "R2 post ack", {31'd0, req_ack}, 1);
    idle();
  endtask

  task automatic t_reset();
    chk(ext_req === 0, "R1 ext_req", {31'd0, ext_req}, 0);
    chk(req_ack === 0, "R1 ack", {31'd0, req_ack}, 0);
  endtask

  task automatic t_post();
    present(1, 0, 0, 32'h1000_0010, 32'hCAFE_0001, 4'b0011);
    chk(req_ack === 1, "R2 same-cycle ack", {31'd0, req_ack}, 1);
    idle();
    chk(ext_req === 1 && ext_write === 1, "R2 ext cycle", {30'd0, ext_req, ext_write}, 3);
    chk(ext_addr === 32'h1000_0010, "R2 addr", ext_addr, 32'h1000_0010);
    chk(ext_wdata === 32'hCAFE_0001, "R2 data", ext_wdata, 32'hCAFE_0001);
    chk(ext_be === 4'b0011, "R2 be", {28'd0, ext_be}, 4'b0011);
    step(); step();
    chk(ext_req === 1 && ext_addr === 32'h1000_0010 && ext_wdata === 32'hCAFE_0001, "R5 held", ext_addr, 32'h1000_0010);
    drain();
    chk(ext_req === 0 && ext_write === 0, "R5 cleared", {30'd0, ext_req, ext_write}, 0);
  endtask

  task automatic t_grant();
    present(1, 0, 0, 32'h2000, 32'h5, 4'hF);
    bus_grant = 0; #1;
    chk(req_ack === 0, "R3 write no grant", {31'd0, req_ack}, 0);
    step();
    chk(req_ack === 0 && ext_req === 0, "R3 still waiting", {30'd0, req_ack, ext_req}, 0);
    @(negedge clk); bus_grant = 1; #5;
    chk(req_ack === 1, "R3 ack at grant", {31'd0, req_ack}, 1);
    idle(); drain();
    present(0, 1, 0, 32'h3000, 0, 4'hF);
    bus_grant = 0; #1;
    chk(req_ack === 0 && per_req === 0, "R3 periph no grant", {30'd0, req_ack, per_req}, 0);
    idle();
  endtask

  task automatic t_full();
    post(32'h4000, 32'hA1, 0);
    present(1, 0, 0, 32'h4004, 32'hA2, 4'hF);
    chk(req_ack === 0, "R4 stall full", {31'd0, req_ack}, 0);
    step();
    chk(req_ack === 0, "R4 stall full 2", {31'd0, req_ack}, 0);
    @(negedge clk); ext_done = 1; #5;
    chk(req_ack === 0, "R4 no ack in done cycle", {31'd0, req_ack}, 0);
    @(negedge clk); ext_done = 0; #5;
    chk(req_ack === 1, "R4 ack after done", {31'd0, req_ack}, 1);
    idle();
    chk(ext_addr === 32'h4004 && ext_wdata === 32'hA2, "R4 second entry", ext_addr, 32'h4004);
    drain();
  endtask

  task automatic t_periph();
    post(32'h5000, 32'hB1, 0);
    present(1, 1, 0, 32'hFFFF_0100, 32'h77, 4'hF);
    chk(req_ack === 1 && per_req === 1 && per_write === 1, "R6 periph write overtakes", {30'd0, req_ack, per_req}, 3);
    @(negedge clk); req_write = 0; per_rdata = 32'hD00D_F00D; #5;
    chk(req_ack === 1 && req_rdata === 32'hD00D_F00D, "R6 periph read data", req_rdata, 32'hD00D_F00D);
    chk(ext_addr === 32'h5000 && ext_write === 1, "R6 ext entry untouched", ext_addr, 32'h5000);
    idle(); drain();
  endtask

  task automatic t_read(input logic [31:0] wa, input logic [31:0] ra, input string tag);
    post(wa, 32'hC1, 0);
    present(0, 0, 0, ra, 0, 4'hF);
    chk(req_ack === 0 && ext_write === 1, {tag, " read waits"}, {30'd0, req_ack, ext_write}, 1);
    @(negedge clk); ext_done = 1; #5;
    chk(req_ack === 0, {tag, " no ack on write done"}, {31'd0, req_ack}, 0);
    @(negedge clk); ext_done = 0; #5;
    chk(ext_req === 1 && ext_write === 0 && ext_addr === ra, {tag, " read issued"}, ext_addr, ra);
    chk(req_ack === 0, {tag, " read pending"}, {31'd0, req_ack}, 0);
    @(negedge clk); ext_done = 1; ext_rdata = 32'h1234_5678; #5;
    chk(req_ack === 1 && req_rdata === 32'h1234_5678, {tag, " read data"}, req_rdata, 32'h1234_5678);
    idle();
  endtask

  task automatic t_dma();
    post(32'h6000, 32'hE1, 1);
    chk(ext_dma === 1, "R9 dma owner", {31'd0, ext_dma}, 1);
    present(0, 1, 1, 32'hFFFF_0200, 0, 4'hF);
    chk(req_ack === 1, "R9 dma periph read proceeds", {31'd0, req_ack}, 1);
    @(negedge clk); req_periph = 0; req_addr = 32'h7000; #5;
    chk(req_ack === 0 && ext_write === 1, "R9 dma ext read waits", {31'd0, req_ack}, 0);
    idle(); drain();
    post(32'h6100, 32'hE2, 0);
    chk(ext_dma === 0, "R9 cpu owner", {31'd0, ext_dma}, 0);
    drain();
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    @(negedge clk); rst_n = 1; #5;
    t_reset();
    t_post();
    t_grant();
    t_full();
    t_periph();
    t_read(32'h8000, 32'h9000, "R7");
    t_read(32'h8800, 32'h8800, "R8");
    t_dma();
    step();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule